// File: doc/BRIEF.md
# Access-Triggered Power State Monitor

This block watches the control, address and data pins of an asynchronous static memory and reports, clock by clock, whether the memory would be drawing full active power or sitting in a reduced-power state. Four qualified pin events wake the part. The first is chip select going active. The second is a write strobe going active while the part is selected. The third is any address bit changing while the part is selected. The fourth is any data bit changing while both chip select and write strobe are active. Each event loads a hold counter. The active flag drops a fixed number of clock cycles after the most recent event. This happens even if the chip stays selected, so the modelled power follows the access rate and not the select pulse width.

A second flag reports deselected standby. It is high whenever the registered chip select is inactive and the hold counter has run out. The four pin groups are registered once. Each event is found by comparing that sample with the sample from the cycle before. The hold delay `HOLD_CYC` and the bus widths are parameters.

Top module: `apd_monitor`

## Requirements
- R1: While `rst` is high and on the cycles that follow it with no event, `active_o` is 0 and `standby_o` is 1. The hold counter is cleared. The sampled chip select resets to inactive (1), the sampled write strobe to inactive (1), and the sampled buses to zero.
- R2: A change of `sel_n` from 1 to 0 that is presented before rising edge k sets `active_o` to 1 after rising edge k+1.
- R3: A change of `wr_n` from 1 to 0 with `sel_n` at 0 in the same sample wakes the block with the same two-edge timing as R2.
- R4: A change of `wr_n` from 1 to 0 while `sel_n` is 1 does not wake the block.
- R5: A change on any bit of `addr` wakes the block only while `sel_n` is 0. The same change while `sel_n` is 1 has no effect.
- R6: A change on any bit of `wdat` wakes the block only while both `sel_n` and `wr_n` are 0. The same change with either of them at 1 has no effect.
- R7: After the last wake event, `active_o` stays 1 for exactly `HOLD_CYC` clock cycles and then falls to 0, even if `sel_n` stays 0 throughout.
- R8: Every wake event reloads the full hold count. A stream of events spaced closer than `HOLD_CYC` cycles keeps `active_o` at 1 without a gap.
- R9: `standby_o` is 1 exactly when the registered `sel_n` is 1 and the hold counter is zero. With `sel_n` held at 1, activity on `wr_n`, `addr` and `wdat` leaves `standby_o` at 1 and `active_o` at 0.
- R10: `active_o` and `standby_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Memory chip select, active low |
| wr_n | input | 1 | Memory write strobe, active low |
| addr | input | AW | Memory address bus |
| wdat | input | DW | Memory data bus |
| active_o | output | 1 | Registered full-power flag |
| standby_o | output | 1 | Registered deselected-standby flag |

## Verification
A pin change that is driven before rising edge k is captured at edge k. It is compared with the previous sample to form the event before edge k+1. It reaches both flags at edge k+1, so each flag is due two rising edges after the stimulus. It then holds for `HOLD_CYC` edges before falling. The bench drives pins on falling edges. It advances its reference model on rising edges, using the samples taken one and two edges earlier. It compares both flags on the following falling edge. The directed checks wait exactly two falling edges after a stimulus for the wake, and `HOLD_CYC` more for the drop.

// File: rtl/apd_pkg.sv
package apd_pkg;
  // positions of the wake causes inside the cause vector
  localparam int CAUSE_SEL   = 0;
  localparam int CAUSE_WRITE = 1;
  localparam int CAUSE_ADDR  = 2;
  localparam int CAUSE_DATA  = 3;
  localparam int NUM_CAUSES  = 4;

  // bits needed to hold the values 0..n
  function automatic int cnt_bits(input int n);
    int b;
    b = 1;
    while ((1 << b) <= n) b++;
    return b;
  endfunction
endpackage

// File: rtl/apd_sampler.sv
// Registers a pin group once and keeps the sample from the cycle before.
module apd_sampler #(
  parameter int              W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      cur  <= pin;
      prev <= cur;
    end
  end
endmodule

// File: rtl/apd_wake_detect.sv
// Qualifies the four pin events that wake the memory.
module apd_wake_detect
  import apd_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 4
) (
  input  logic          sel_n_cur,
  input  logic          sel_n_prev,
  input  logic          wr_n_cur,
  input  logic          wr_n_prev,
  input  logic [AW-1:0] addr_cur,
  input  logic [AW-1:0] addr_prev,
  input  logic [DW-1:0] data_cur,
  input  logic [DW-1:0] data_prev,
  output logic          wake
);
  logic [NUM_CAUSES-1:0] cause;
  logic                  selected;

  always_comb begin
    selected           = ~sel_n_cur;
    cause              = '0;
    cause[CAUSE_SEL]   = sel_n_prev & ~sel_n_cur;
    cause[CAUSE_WRITE] = selected & wr_n_prev & ~wr_n_cur;
    cause[CAUSE_ADDR]  = selected & (|(addr_cur ^ addr_prev));
    cause[CAUSE_DATA]  = selected & ~wr_n_cur & (|(data_cur ^ data_prev));
    wake               = |cause;
  end
endmodule

// File: rtl/apd_hold_timer.sv
// Retriggerable hold counter and the registered power flags.
module apd_hold_timer
  import apd_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wake,
  input  logic desel,
  output logic active_o,
  output logic standby_o
);
  localparam int CW = cnt_bits(HOLD_CYC);
  localparam logic [CW-1:0] FULL = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (wake)             cnt_d = FULL;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                  cnt_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      active_o  <= 1'b0;
      standby_o <= 1'b1;
    end else begin
      cnt_q     <= cnt_d;
      active_o  <= (cnt_d != '0);
      standby_o <= desel & (cnt_d == '0);
    end
  end
endmodule

// File: rtl/apd_monitor.sv
module apd_monitor #(
  parameter int AW       = 18,
  parameter int DW       = 4,
  parameter int HOLD_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdat,
  output logic          active_o,
  output logic          standby_o
);
  logic [1:0]    ctl_cur, ctl_prev;
  logic [AW-1:0] a_cur, a_prev;
  logic [DW-1:0] d_cur, d_prev;
  logic          wake;

  // bit 1: chip select, bit 0: write strobe (both idle high)
  apd_sampler #(.W(2), .RST_VAL(2'b11)) u_ctl (
    .clk(clk), .rst(rst), .pin({sel_n, wr_n}), .cur(ctl_cur), .prev(ctl_prev));
  apd_sampler #(.W(AW), .RST_VAL('0)) u_addr (
    .clk(clk), .rst(rst), .pin(addr), .cur(a_cur), .prev(a_prev));
  apd_sampler #(.W(DW), .RST_VAL('0)) u_data (
    .clk(clk), .rst(rst), .pin(wdat), .cur(d_cur), .prev(d_prev));

  apd_wake_detect #(.AW(AW), .DW(DW)) u_det (
    .sel_n_cur(ctl_cur[1]), .sel_n_prev(ctl_prev[1]),
    .wr_n_cur(ctl_cur[0]),  .wr_n_prev(ctl_prev[0]),
    .addr_cur(a_cur), .addr_prev(a_prev),
    .data_cur(d_cur), .data_prev(d_prev),
    .wake(wake));

  apd_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_tmr (
    .clk(clk), .rst(rst), .wake(wake), .desel(ctl_cur[1]),
    .active_o(active_o), .standby_o(standby_o));
endmodule

// File: rtl/apd_monitor_chk.sv
module apd_monitor_chk #(
  parameter int AW = 18,
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          sel_n,
  input logic          wr_n,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdat,
  input logic          act,
  input logic          stby
);
  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(act && stby));

  a_r2_select_wakes: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_n) |-> ##2 act);

  a_r3_write_wakes: assert property (@(posedge clk) disable iff (rst)
    ($fell(wr_n) && !sel_n) |-> ##2 act);

  a_r5_addr_wakes: assert property (@(posedge clk) disable iff (rst)
    (!$stable(addr) && !sel_n) |-> ##2 act);

  a_r6_data_wakes: assert property (@(posedge clk) disable iff (rst)
    (!$stable(wdat) && !sel_n && !wr_n) |-> ##2 act);

  a_r9_standby_deselected: assert property (@(posedge clk) disable iff (rst)
    stby |-> $past(sel_n, 2));
endmodule

bind apd_monitor apd_monitor_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .addr(addr),
  .wdat(wdat), .act(active_o), .stby(standby_o));

// File: tb/apd_monitor_bench.sv
module apd_monitor_bench;
  localparam int AW   = 8;
  localparam int DW   = 4;
  localparam int HOLD = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_n = 1'b1;
  logic          wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdat = '0;
  logic          active_o, standby_o;

  apd_monitor #(.AW(AW), .DW(DW), .HOLD_CYC(HOLD)) u_apd_monitor (
    .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .addr(addr),
    .wdat(wdat), .active_o(active_o), .standby_o(standby_o));

  always #4 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string phase = "R1";

  // behavioural reference: history of pin samples and remaining hold cycles
  typedef struct packed {
    logic          s;
    logic          w;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } snap_t;
  snap_t hist[2];
  int    remain;
  bit    e_act, e_stby, ev;

  always @(posedge clk) begin
    if (rst) begin
      hist[0] = '{s: 1'b1, w: 1'b1, a: '0, d: '0};
      hist[1] = hist[0];
      remain  = 0;
      e_act   = 1'b0;
      e_stby  = 1'b1;
    end else begin
      ev = (hist[1].s && !hist[0].s)
        || (!hist[0].s && hist[1].w && !hist[0].w)
        || (!hist[0].s && hist[0].a != hist[1].a)
        || (!hist[0].s && !hist[0].w && hist[0].d != hist[1].d);
      if (ev) remain = HOLD;
      else if (remain > 0) remain = remain - 1;
      e_act   = (remain > 0);
      e_stby  = hist[0].s && (remain == 0);
      hist[1] = hist[0];
      hist[0] = '{s: sel_n, w: wr_n, a: addr, d: wdat};
    end
  end

  task automatic check(input string req, input string what,
                       input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(phase, "active_o", active_o, e_act);
      check(phase, "standby_o", standby_o, e_stby);
      check("R10", "exclusive", active_o & standby_o, 1'b0);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1: reset state
    check("R1", "active after reset", active_o, 1'b0);
    check("R1", "standby after reset", standby_o, 1'b1);
    cyc(3);

    // R2: select falls, wake two edges later
    phase = "R2";
    sel_n = 1'b0;
    cyc(2);
    check("R2", "active after select", active_o, 1'b1);
    // R7: held exactly HOLD cycles while still selected
    phase = "R7";
    cyc(HOLD - 1);
    check("R7", "active at last hold cycle", active_o, 1'b1);
    cyc(1);
    check("R7", "active dropped while selected", active_o, 1'b0);
    check("R9", "no standby while selected", standby_o, 1'b0);
    cyc(3);

    // R3: write strobe falls while selected
    phase = "R3";
    wr_n = 1'b0;
    cyc(2);
    check("R3", "active after write strobe", active_o, 1'b1);
    cyc(HOLD + 2);

    // R6: data change with both active wakes
    phase = "R6";
    wdat = 4'h5;
    cyc(2);
    check("R6", "active after data change", active_o, 1'b1);
    wr_n = 1'b1;
    cyc(HOLD + 3);
    wdat = 4'hA;    // write strobe inactive: no effect
    cyc(2);
    check("R6", "data change without write ignored", active_o, 1'b0);
    cyc(3);

    // R5: address change while selected
    phase = "R5";
    addr = 8'h3C;
    cyc(2);
    check("R5", "active after address change", active_o, 1'b1);
    cyc(HOLD + 2);

    // R8: address stream spaced below the hold keeps active
    phase = "R8";
    for (int i = 0; i < 10; i++) begin
      addr = addr + 8'd1;
      cyc(HOLD - 2);
      if (i > 0) check("R8", "active during stream", active_o, 1'b1);
    end
    cyc(HOLD + 2);

    // R4/R9: deselected, every other pin toggles
    phase = "R9";
    sel_n = 1'b1;
    cyc(HOLD + 2);
    check("R9", "standby when deselected", standby_o, 1'b1);
    phase = "R4";
    wr_n = 1'b0;
    cyc(2);
    check("R4", "write strobe while deselected", active_o, 1'b0);
    phase = "R5";
    for (int i = 0; i < 6; i++) begin
      addr = addr ^ 8'hFF;
      wdat = wdat + 4'd3;
      wr_n = ~wr_n;
      cyc(1);
    end
    cyc(1);
    check("R5", "address change while deselected", active_o, 1'b0);
    check("R9", "standby kept under activity", standby_o, 1'b1);

    // R2 again with a short select pulse: power still held HOLD cycles
    phase = "R2";
    wr_n = 1'b1;
    cyc(1);
    sel_n = 1'b0;
    cyc(1);
    sel_n = 1'b1;
    cyc(1);
    check("R2", "active after short select", active_o, 1'b1);
    check("R10", "standby low while held", standby_o, 1'b0);
    cyc(HOLD + 2);
    check("R9", "standby back after hold", standby_o, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule